// File: doc/BRIEF.md
# Double-Precision Compare-to-Mask Unit

This unit compares two IEEE-754 binary64 values held in 128-bit vector source registers. It produces a 128-bit mask for the destination register. Only the upper doubleword of each source takes part in the comparison. A true outcome fills the upper doubleword of the result with ones. The lower doubleword of the result is always zero.

Four operations are selected by a 2-bit code: equal, not-equal, greater-or-equal and greater-than. The unit classifies each operand as a number, a quiet NaN or a signaling NaN, and treats positive and negative zero as equal. It produces two one-cycle status pulses for the status register kept outside the unit:
- a signaling-NaN invalid flag;
- an invalid-compare flag, raised by the ordered operations only.

An exception-enable input decides whether an invalid condition blocks the destination write. The write-enable output tells the register file whether to store the mask.

Operands are taken on a valid strobe. All results appear together one clock later, marked by an output valid.

Top module: `fp64_cmp_mask`

## Requirements
- R1: Every output is registered. `outValid` is high exactly in the cycle after a cycle with `inValid` high. When `outValid` is low, `writeEn`, `flagSnan` and `flagInvCmp` are low.
- R2: A synchronous active-high reset clears `outValid`, `writeEn`, both flags and `result` to zero.
- R3: Doubleword 0 of a source is bits [127:64]. Bits [63:0] of both sources have no effect on any output.
- R4: When the comparison is true, `result[127:64]` is all ones and `result[63:0]` is zero. When it is false, `result` is all zero.
- R5: The operation codes are 0 equal (A == B), 1 not-equal (the inverse of equal), 2 greater-or-equal (A >= B) and 3 greater-than (A > B). Here A is `srcA[127:64]` and B is `srcB[127:64]`.
- R6: Non-NaN values are ordered by sign and magnitude. Among negatives, the larger magnitude is the smaller value. Infinities are the extremes. +0 and -0 compare equal.
- R7: A NaN has exponent bits [62:52] all ones and a nonzero fraction [51:0]. Any NaN operand makes the equal, greater-or-equal and greater-than operations false, and makes not-equal true.
- R8: A NaN with fraction bit 51 clear is signaling. `flagSnan` pulses whenever either operand is signaling, for all four operations.
- R9: For codes 2 and 3, `flagInvCmp` pulses in two cases: a signaling NaN is present while `excEnable` is 0, or no signaling NaN is present but a quiet NaN (fraction bit 51 set) is.
- R10: Codes 0 and 1 never raise `flagInvCmp`.
- R11: `writeEn` is low when `excEnable` was 1 and either flag is raised. Otherwise `writeEn` is high with `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and operation are presented this cycle |
| op | input | 2 | Operation code: 0 eq, 1 ne, 2 ge, 3 gt |
| excEnable | input | 1 | Invalid-operation exception enable |
| srcA | input | 128 | First source register |
| srcB | input | 128 | Second source register |
| outValid | output | 1 | Result, write enable and flags are valid |
| result | output | 128 | Compare mask for the destination |
| writeEn | output | 1 | Destination register write permitted |
| flagSnan | output | 1 | Signaling-NaN invalid pulse |
| flagInvCmp | output | 1 | Invalid-compare pulse |

## Verification
Every result of this unit (mask, write enable, both flags and the output valid) is due in the cycle after the one in which `inValid` is sampled high. The bench drives each operation on a falling edge and lets the next rising edge capture it. It then reads all outputs on the following falling edge, so each check lands in the single cycle where that result is defined. Idle checks one cycle after `inValid` drops confirm that the flags and the write enable pulse for no longer than one cycle. Operations issued back to back check that each result belongs to its own operands.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

  typedef enum logic [1:0] {
    OP_EQ = 2'd0,
    OP_NE = 2'd1,
    OP_GE = 2'd2,
    OP_GT = 2'd3
  } cmpOp_e;

  // Classification and raw ordering reported by the datapath
  typedef struct packed {
    logic aNan;
    logic aSnan;
    logic bNan;
    logic bSnan;
    logic eq;
    logic gt;
  } cmpStatus_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic maskTrue;
  } dpStrobe_t;

endpackage

// File: rtl/fcm_datapath.sv
module fcm_datapath
  import fcm_pkg::*;
#(
  parameter int REG_W = 128,
  parameter int DW_W  = 64,
  parameter int EXP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  dpStrobe_t        strobe,
  output cmpStatus_t       status,
  output logic [REG_W-1:0] result
);

  localparam int FRAC_W = DW_W - 1 - EXP_W;
  localparam int QBIT   = FRAC_W - 1;
  localparam int LANES  = REG_W / DW_W;
  localparam int MAG_W  = DW_W - 1;

  logic [DW_W-1:0]  opnd [2];
  logic [MAG_W-1:0] mag  [2];
  logic [1:0]       sgn;
  logic [1:0]       isNan;
  logic [1:0]       isSnan;
  logic [1:0]       isZero;

  // doubleword 0 sits in the upper half of each source
  assign opnd[0] = srcA[REG_W-1 -: DW_W];
  assign opnd[1] = srcB[REG_W-1 -: DW_W];

  generate
    for (genvar k = 0; k < 2; k++) begin : g_cls
      logic [EXP_W-1:0]  expF;
      logic [FRAC_W-1:0] fracF;
      assign expF      = opnd[k][DW_W-2 -: EXP_W];
      assign fracF     = opnd[k][FRAC_W-1:0];
      assign sgn[k]    = opnd[k][DW_W-1];
      assign mag[k]    = opnd[k][MAG_W-1:0];
      assign isNan[k]  = (&expF) && (|fracF);
      assign isSnan[k] = isNan[k] && !fracF[QBIT];
      assign isZero[k] = ~|mag[k];
    end
  endgenerate

  logic bothZero;
  logic magEq;
  logic magGt;
  logic magLt;
  logic eqRaw;
  logic gtRaw;

  always_comb begin
    bothZero = isZero[0] && isZero[1];
    magEq    = (mag[0] == mag[1]);
    magGt    = (mag[0] > mag[1]);
    magLt    = (mag[0] < mag[1]);
    eqRaw    = bothZero || ((sgn[0] == sgn[1]) && magEq);
    if (bothZero)              gtRaw = 1'b0;
    else if (sgn[0] != sgn[1]) gtRaw = !sgn[0];
    else if (!sgn[0])          gtRaw = magGt;
    else                       gtRaw = magLt;
  end

  always_comb begin
    status.aNan  = isNan[0];
    status.aSnan = isSnan[0];
    status.bNan  = isNan[1];
    status.bSnan = isSnan[1];
    status.eq    = eqRaw;
    status.gt    = gtRaw;
  end

  // one register slice per doubleword lane; only the top lane carries the mask
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          result[l*DW_W +: DW_W] <= '0;
        end else if (strobe.capture) begin
          if (l == LANES - 1) result[l*DW_W +: DW_W] <= {DW_W{strobe.maskTrue}};
          else                result[l*DW_W +: DW_W] <= '0;
        end
      end
    end
  endgenerate

  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (result[REG_W-DW_W-1:0] == '0) &&
    ((result[REG_W-1 -: DW_W] == '0) || (&result[REG_W-1 -: DW_W])));

endmodule

// File: rtl/fcm_control.sv
module fcm_control
  import fcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] op,
  input  logic       excEnable,
  input  cmpStatus_t status,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic       writeEn,
  output logic       flagSnan,
  output logic       flagInvCmp
);

  cmpOp_e opc;
  logic   anyNan;
  logic   snanSeen;
  logic   qnanSeen;
  logic   ordered;
  logic   cmpTrue;
  logic   invCmpNow;
  logic   suppress;

  always_comb begin
    opc      = cmpOp_e'(op);
    anyNan   = status.aNan || status.bNan;
    snanSeen = status.aSnan || status.bSnan;
    qnanSeen = (status.aNan && !status.aSnan) || (status.bNan && !status.bSnan);
    ordered  = (opc == OP_GE) || (opc == OP_GT);
    unique case (opc)
      OP_EQ:   cmpTrue = !anyNan && status.eq;
      OP_NE:   cmpTrue = anyNan || !status.eq;
      OP_GE:   cmpTrue = !anyNan && (status.eq || status.gt);
      OP_GT:   cmpTrue = !anyNan && status.gt;
      default: cmpTrue = 1'b0;
    endcase
    invCmpNow = ordered && (snanSeen ? !excEnable : qnanSeen);
    suppress  = excEnable && (snanSeen || invCmpNow);
  end

  always_comb begin
    strobe.capture  = inValid;
    strobe.maskTrue = cmpTrue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      writeEn    <= 1'b0;
      flagSnan   <= 1'b0;
      flagInvCmp <= 1'b0;
    end else begin
      outValid   <= inValid;
      writeEn    <= inValid && !suppress;
      flagSnan   <= inValid && snanSeen;
      flagInvCmp <= inValid && invCmpNow;
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !(writeEn || flagSnan || flagInvCmp));

  // R8
  snan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && (status.aSnan || status.bSnan)) |=> flagSnan);

  // R10
  unordered_no_vxc_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !op[1]) |=> !flagInvCmp);

  // R11
  write_block_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && excEnable) |=> !(writeEn && (flagSnan || flagInvCmp)));

endmodule

// File: rtl/fp64_cmp_mask.sv
module fp64_cmp_mask
  import fcm_pkg::*;
#(
  parameter int REG_W = 128,
  parameter int DW_W  = 64,
  parameter int EXP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       op,
  input  logic             excEnable,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  output logic             outValid,
  output logic [REG_W-1:0] result,
  output logic             writeEn,
  output logic             flagSnan,
  output logic             flagInvCmp
);

  cmpStatus_t cmpStatus;
  dpStrobe_t  dpStrobe;

  fcm_datapath #(
    .REG_W(REG_W),
    .DW_W (DW_W),
    .EXP_W(EXP_W)
  ) u_datapath (
    .clk   (clk),
    .rst   (rst),
    .srcA  (srcA),
    .srcB  (srcB),
    .strobe(dpStrobe),
    .status(cmpStatus),
    .result(result)
  );

  fcm_control u_control (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .op        (op),
    .excEnable (excEnable),
    .status    (cmpStatus),
    .strobe    (dpStrobe),
    .outValid  (outValid),
    .writeEn   (writeEn),
    .flagSnan  (flagSnan),
    .flagInvCmp(flagInvCmp)
  );

endmodule

// File: tb/fp64_cmp_mask_bench.sv
module fp64_cmp_mask_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] P_TWO  = 64'h4000000000000000;
  localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] N_TWO  = 64'hC000000000000000;
  localparam logic [63:0] P_ZERO = 64'h0000000000000000;
  localparam logic [63:0] N_ZERO = 64'h8000000000000000;
  localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] P_MAX  = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] QNAN   = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN   = 64'h7FF0000000000001;
  localparam logic [63:0] NSNAN  = 64'hFFF4000000000000;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [1:0]   op;
  logic         excEnable;
  logic [127:0] srcA;
  logic [127:0] srcB;
  logic         outValid;
  logic [127:0] result;
  logic         writeEn;
  logic         flagSnan;
  logic         flagInvCmp;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp64_cmp_mask u_fp64_cmp_mask (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .op        (op),
    .excEnable (excEnable),
    .srcA      (srcA),
    .srcB      (srcB),
    .outValid  (outValid),
    .result    (result),
    .writeEn   (writeEn),
    .flagSnan  (flagSnan),
    .flagInvCmp(flagInvCmp)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isNanF(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic bit isSnanF(input logic [63:0] v);
    return isNanF(v) && !v[51];
  endfunction

  // reference truth from the requirements, using real arithmetic for numbers
  function automatic bit refTruth(input logic [1:0] code, input logic [63:0] a,
                                  input logic [63:0] b);
    real ra;
    real rb;
    if (isNanF(a) || isNanF(b)) return (code == 2'd1);
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (code)
      2'd0:    return ra == rb;
      2'd1:    return ra != rb;
      2'd2:    return ra >= rb;
      default: return ra > rb;
    endcase
  endfunction

  task automatic runOp(input logic [1:0] code, input logic [63:0] a, input logic [63:0] b,
                       input bit exc, input logic [63:0] loA, input logic [63:0] loB,
                       input string tag);
    bit truth;
    bit sn;
    bit qn;
    bit inv;
    bit we;
    logic [127:0] expRes;
    truth  = refTruth(code, a, b);
    sn     = isSnanF(a) || isSnanF(b);
    qn     = (isNanF(a) && !isSnanF(a)) || (isNanF(b) && !isSnanF(b));
    inv    = code[1] && (sn ? !exc : qn);
    we     = !(exc && (sn || inv));
    expRes = truth ? {64'hFFFFFFFFFFFFFFFF, 64'd0} : 128'd0;
    inValid   = 1'b1;
    op        = code;
    excEnable = exc;
    srcA      = {a, loA};
    srcB      = {b, loB};
    @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b1, {"R1 outValid ", tag}, {127'd0, outValid}, 128'd1);
    check(result == expRes, {"R4 R5 result ", tag}, result, expRes);
    check(flagSnan == sn, {"R8 flagSnan ", tag}, {127'd0, flagSnan}, {127'd0, sn});
    check(flagInvCmp == inv, {"R9 flagInvCmp ", tag}, {127'd0, flagInvCmp}, {127'd0, inv});
    check(writeEn == we, {"R11 writeEn ", tag}, {127'd0, writeEn}, {127'd0, we});
  endtask

  task automatic goIdle(input string tag);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, {"R1 idle outValid ", tag}, {127'd0, outValid}, 128'd0);
    check({writeEn, flagSnan, flagInvCmp} == 3'b000, {"R1 idle pulses ", tag},
          {125'd0, writeEn, flagSnan, flagInvCmp}, 128'd0);
  endtask

  task automatic t_reset;
    rst       = 1'b1;
    inValid   = 1'b1;
    op        = 2'd1;
    excEnable = 1'b0;
    srcA      = {P_ONE, 64'd5};
    srcB      = {P_TWO, 64'd9};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: all outputs cleared while reset is held
    check(outValid == 1'b0, "R2 outValid", {127'd0, outValid}, 128'd0);
    check(result == 128'd0, "R2 result", result, 128'd0);
    check({writeEn, flagSnan, flagInvCmp} == 3'b000, "R2 pulses",
          {125'd0, writeEn, flagSnan, flagInvCmp}, 128'd0);
    inValid = 1'b0;
    rst     = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_ordering;
    // R5 R6: basic ordering, back to back
    for (int c = 0; c < 4; c++) begin
      runOp(2'(c), P_ONE, P_TWO, 1'b0, 64'd0, 64'd0, "R6 1 vs 2");
      runOp(2'(c), P_TWO, P_ONE, 1'b0, 64'd0, 64'd0, "R6 2 vs 1");
      runOp(2'(c), N_ONE, N_TWO, 1'b0, 64'd0, 64'd0, "R6 -1 vs -2");
      runOp(2'(c), N_TWO, N_ONE, 1'b0, 64'd0, 64'd0, "R6 -2 vs -1");
      runOp(2'(c), P_ONE, P_ONE, 1'b0, 64'd0, 64'd0, "R5 equal");
      runOp(2'(c), N_ONE, P_ONE, 1'b0, 64'd0, 64'd0, "R6 -1 vs 1");
      runOp(2'(c), P_ZERO, N_ZERO, 1'b0, 64'd0, 64'd0, "R6 +0 vs -0");
      runOp(2'(c), N_ZERO, P_ZERO, 1'b0, 64'd0, 64'd0, "R6 -0 vs +0");
      runOp(2'(c), P_INF, P_MAX, 1'b0, 64'd0, 64'd0, "R6 inf vs max");
      runOp(2'(c), N_INF, N_TWO, 1'b0, 64'd0, 64'd0, "R6 -inf vs -2");
      runOp(2'(c), N_ZERO, N_ONE, 1'b1, 64'd0, 64'd0, "R6 -0 vs -1 exc");
    end
    goIdle("after ordering");
  endtask

  task automatic t_lowbits;
    // R3: lower doublewords differ but must not matter
    runOp(2'd0, P_TWO, P_TWO, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321,
          "R3 eq lowbits");
    runOp(2'd3, P_ONE, P_TWO, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R3 gt lowbits");
    runOp(2'd2, P_ONE, P_ONE, 1'b0, 64'd0, 64'h7FF0_0000_0000_0001, "R3 snan-like low");
    goIdle("after lowbits");
  endtask

  task automatic t_nan;
    // R7 R8 R9 R10 R11 over every opcode and both enable settings
    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 2; e++) begin
        runOp(2'(c), QNAN, P_ONE, 1'(e), 64'd0, 64'd0, "R7 R9 qnan A");
        runOp(2'(c), P_ONE, QNAN, 1'(e), 64'd0, 64'd0, "R7 R9 qnan B");
        runOp(2'(c), SNAN, P_ONE, 1'(e), 64'd0, 64'd0, "R8 snan A");
        runOp(2'(c), P_ONE, NSNAN, 1'(e), 64'd0, 64'd0, "R8 snan B");
        runOp(2'(c), SNAN, QNAN, 1'(e), 64'd0, 64'd0, "R8 R9 snan+qnan");
        runOp(2'(c), QNAN, QNAN, 1'(e), 64'd0, 64'd0, "R7 R10 qnan both");
      end
    end
    goIdle("after nan");
  endtask

  task automatic t_explicit;
    // R10: equal with signaling NaN and enable low never flags invalid-compare
    runOp(2'd0, SNAN, P_ONE, 1'b0, 64'd0, 64'd0, "R10 eq snan");
    check(flagInvCmp == 1'b0, "R10 eq snan no vxc", {127'd0, flagInvCmp}, 128'd0);
    // R11: enabled ordered quiet-NaN compare blocks the write
    runOp(2'd3, QNAN, P_ONE, 1'b1, 64'd0, 64'd0, "R11 gt qnan exc");
    check(writeEn == 1'b0, "R11 write blocked", {127'd0, writeEn}, 128'd0);
    // R7: not-equal with a NaN is true
    runOp(2'd1, QNAN, QNAN, 1'b0, 64'd0, 64'd0, "R7 ne nan");
    check(result[127:64] == 64'hFFFF_FFFF_FFFF_FFFF, "R7 ne nan true",
          result, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    goIdle("after explicit");
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst       = 1'b1;
    inValid   = 1'b0;
    op        = 2'd0;
    excEnable = 1'b0;
    srcA      = '0;
    srcB      = '0;
    @(negedge clk);
    t_reset();
    t_ordering();
    t_lowbits();
    t_nan();
    t_explicit();
    done = 1'b1;
    finishRun();
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

endmodule